// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block is the acknowledge side of a programmable interrupt controller for a processor that answers an interrupt with a three-byte call. Eight request lines feed an edge-detecting request latch. A fixed-priority resolver, with level 0 as the most urgent, compares the pending unmasked requests against the levels already in service. When a request is more urgent than every level in service, the block raises its interrupt output.

The processor then issues three active-low acknowledge pulses. The block answers them with three bytes: a call opcode, a low address byte and a high address byte. The low byte carries the interrupt level in a field whose position depends on whether vector entries are spaced four or eight bytes apart. The level is frozen at the first pulse, and the in-service bit is set at that point.

The in-service bit is cleared in one of two ways. In automatic mode it clears when the second pulse ends. Otherwise it clears on a non-specific end-of-interrupt strobe, which always retires the most urgent in-service level. Levels marked as slave inputs have their number driven on a cascade address output, and the slave then supplies the two address bytes. A request that disappears before the first pulse is answered as level 7. In that case no in-service bit is set and the cascade output stays idle.

Top module: `irq_ack_sequencer`

## Requirements
- R1: After reset, int_out, data_oe, cas_out and in_service are all zero. A request bit is latched only on a rising edge of its req_in line. The latch is discarded if the line falls before the first acknowledge pulse. A line held high after its acknowledge does not request again.
- R2: int_out rises two clock cycles after a latched request edge if the request is unmasked (irq_mask bit 0) and its level number is lower than every set in_service bit. Masked requests and requests that lose to an in-service level leave int_out low.
- R3: When several requests are eligible at the first pulse, the lowest level number is acknowledged.
- R4: During the first acknowledge pulse the data byte is 0xCD and data_oe is 1, also for slave levels.
- R5: During the second pulse the byte depends on step_is_8. With step_is_8=0 the byte is vec_base_lo[7:5], then the 3-bit level, then 2'b00 (MSB first). With step_is_8=1 it is vec_base_lo[7:6], then the level, then 3'b000.
- R6: During the third pulse the byte is vec_base_hi.
- R7: The in_service bit of the acknowledged level is set from the first pulse. With auto_eoi=1 it clears at the end of the second pulse. With auto_eoi=0 it stays set through the whole sequence.
- R8: A one-cycle eoi strobe clears only the lowest-numbered set in_service bit.
- R9: If no request is eligible at the first pulse, the sequence answers as level 7 and in_service is left unchanged.
- R10: For a real request on a level whose slave_map bit is 1, cas_out carries the level number from the first pulse through the end of the third, and data_oe stays 0 for the second and third bytes. For the spurious level-7 case, cas_out stays 0 and all three bytes are driven.
- R11: data_oe is 1 only while inta_n is low and this controller owns the byte. It follows inta_n with one cycle of delay on both edges.
- R12: int_out is 0 from the cycle after the first pulse starts until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_LVL | Interrupt request lines, rising-edge latched |
| irq_mask | input | N_LVL | Per-level mask, 1 blocks the level |
| slave_map | input | N_LVL | Per-level flag, 1 marks a cascaded slave |
| vec_base_lo | input | 8 | Programmed low address bits (upper bits used) |
| vec_base_hi | input | 8 | Programmed high address byte |
| step_is_8 | input | 1 | Vector spacing: 0 four bytes, 1 eight bytes |
| auto_eoi | input | 1 | Clear in-service at end of second pulse |
| inta_n | input | 1 | Acknowledge pulses, active low, synchronous |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| int_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Acknowledge byte |
| data_oe | output | 1 | Data output enable |
| cas_out | output | LVL_W | Cascade address for the slave |
| in_service | output | N_LVL | In-service register |

## Verification
Each output is registered, so every result appears one clock edge after the input that causes it. The acknowledge byte, data_oe and cas_out are therefore read one cycle after inta_n is driven low, and the release of data_oe one cycle after it returns high. The automatic in-service clear is read in that same cycle. A request edge needs two edges before int_out can show it, so the bench waits three cycles before reading int_out. Because inputs change and outputs are read on the falling clock edge, every check lands after the registers that carry its result have updated.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_B1,
    SEQ_B2,
    SEQ_B3
  } seq_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  // lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_byte.sv
module irq_vec_byte
  import irq_ack_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  seq_t             sel,
  input  logic [LVL_W-1:0] lvl,
  input  logic [7:0]       base_lo,
  input  logic [7:0]       base_hi,
  input  logic             step_is_8,
  output logic [7:0]       byte_o
);
  logic [7:0] low_byte;

  always_comb begin
    if (step_is_8) low_byte = {base_lo[7:6], lvl[2:0], 3'b000};
    else           low_byte = {base_lo[7:5], lvl[2:0], 2'b00};
  end

  always_comb begin
    case (sel)
      SEQ_B1:  byte_o = CALL_OPCODE;
      SEQ_B2:  byte_o = low_byte;
      SEQ_B3:  byte_o = base_hi;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
  import irq_ack_pkg::*;
#(
  parameter int N_LVL = 8,
  parameter int LVL_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] req_in,
  input  logic [N_LVL-1:0] irq_mask,
  input  logic [N_LVL-1:0] slave_map,
  input  logic [7:0]       vec_base_lo,
  input  logic [7:0]       vec_base_hi,
  input  logic             step_is_8,
  input  logic             auto_eoi,
  input  logic             inta_n,
  input  logic             eoi,
  output logic             int_out,
  output logic [7:0]       data_out,
  output logic             data_oe,
  output logic [LVL_W-1:0] cas_out,
  output logic [N_LVL-1:0] in_service
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N_LVL - 1);

  logic [N_LVL-1:0] req_q, irr, irr_n, isr_n;
  logic             inta_q, fall, rise, take;
  seq_t             seq, seq_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             spur_q, spur_n, slv_q, slv_n, own_n;
  logic             p_found, s_found, eligible;
  logic [LVL_W-1:0] p_idx, s_idx;
  logic [7:0]       byte_n;

  irq_lowest_pick #(.N(N_LVL), .W(LVL_W)) u_pend_pick (
    .vec(irr & ~irq_mask), .found(p_found), .idx(p_idx)
  );

  irq_lowest_pick #(.N(N_LVL), .W(LVL_W)) u_isr_pick (
    .vec(in_service), .found(s_found), .idx(s_idx)
  );

  assign eligible = p_found && (!s_found || (p_idx < s_idx));
  assign fall     = inta_q && !inta_n;
  assign rise     = !inta_q && inta_n;
  assign take     = (seq == SEQ_IDLE) && fall;

  // pulse sequencing
  always_comb begin
    seq_n = seq;
    case (seq)
      SEQ_IDLE: if (fall) seq_n = SEQ_B1;
      SEQ_B1:   if (fall) seq_n = SEQ_B2;
      SEQ_B2:   if (fall) seq_n = SEQ_B3;
      SEQ_B3:   if (rise) seq_n = SEQ_IDLE;
      default:  seq_n = SEQ_IDLE;
    endcase
  end

  // level freeze at the first pulse
  always_comb begin
    lvl_n  = lvl_q;
    spur_n = spur_q;
    slv_n  = slv_q;
    if (take) begin
      spur_n = !eligible;
      lvl_n  = eligible ? p_idx : SPUR_LVL;
      slv_n  = eligible && slave_map[p_idx];
    end
  end

  // request latch and in-service update
  always_comb begin
    irr_n = (irr | (req_in & ~req_q)) & req_in;
    if (take && eligible) irr_n[p_idx] = 1'b0;

    isr_n = in_service;
    if (eoi && s_found) isr_n[s_idx] = 1'b0;
    if (take && eligible) isr_n[p_idx] = 1'b1;
    if (auto_eoi && (seq == SEQ_B2) && rise && !spur_q) isr_n[lvl_q] = 1'b0;
  end

  assign own_n = (seq_n == SEQ_B1) || !slv_n;

  irq_vec_byte #(.LVL_W(LVL_W)) u_byte (
    .sel(seq_n), .lvl(lvl_n), .base_lo(vec_base_lo), .base_hi(vec_base_hi),
    .step_is_8(step_is_8), .byte_o(byte_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= '0;
      irr        <= '0;
      in_service <= '0;
      inta_q     <= 1'b1;
      seq        <= SEQ_IDLE;
      lvl_q      <= '0;
      spur_q     <= 1'b0;
      slv_q      <= 1'b0;
      int_out    <= 1'b0;
      data_out   <= 8'h00;
      data_oe    <= 1'b0;
      cas_out    <= '0;
    end else begin
      req_q      <= req_in;
      irr        <= irr_n;
      in_service <= isr_n;
      inta_q     <= inta_n;
      seq        <= seq_n;
      lvl_q      <= lvl_n;
      spur_q     <= spur_n;
      slv_q      <= slv_n;
      int_out    <= (seq_n == SEQ_IDLE) && eligible;
      data_out   <= byte_n;
      data_oe    <= !inta_n && (seq_n != SEQ_IDLE) && own_n;
      cas_out    <= ((seq_n != SEQ_IDLE) && slv_n) ? lvl_n : '0;
    end
  end
endmodule

// File: rtl/irq_ack_sequencer_chk.sv
module irq_ack_sequencer_chk
  import irq_ack_pkg::*;
#(
  parameter int N_LVL = 8,
  parameter int LVL_W = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst,
  input logic             inta_n,
  input logic             eoi,
  input logic             int_out,
  input logic             data_oe,
  input logic [7:0]       data_out,
  input logic [LVL_W-1:0] cas_out,
  input logic [N_LVL-1:0] in_service
);
  assert_oe_in_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !$past(inta_n));

  assert_int_quiet_in_ack_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(inta_n) |-> !int_out);

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi && inta_n && $past(inta_n) && (in_service != '0))
      |=> ($countones(in_service) + 1 == $countones($past(in_service))));

  assert_slave_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ((cas_out != '0) && data_oe) |-> (data_out == CALL_OPCODE));

  assert_isr_grows_on_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_service) > $countones($past(in_service))) |-> !$past(inta_n));
endmodule

bind irq_ack_sequencer irq_ack_sequencer_chk #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .inta_n(inta_n), .eoi(eoi), .int_out(int_out),
  .data_oe(data_oe), .data_out(data_out), .cas_out(cas_out), .in_service(in_service)
);

// File: tb/irq_ack_sequencer_test.sv
`timescale 1ns/1ps
module irq_ack_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_in = '0, irq_mask = '0, slave_map = '0;
  logic [7:0] vec_base_lo = '0, vec_base_hi = '0;
  logic       step_is_8 = 1'b0, auto_eoi = 1'b0, inta_n = 1'b1, eoi = 1'b0;
  logic       int_out, data_oe;
  logic [7:0] data_out;
  logic [2:0] cas_out;
  logic [7:0] in_service;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_ack_sequencer uut (
    .clk(clk), .rst(rst), .req_in(req_in), .irq_mask(irq_mask), .slave_map(slave_map),
    .vec_base_lo(vec_base_lo), .vec_base_hi(vec_base_hi), .step_is_8(step_is_8),
    .auto_eoi(auto_eoi), .inta_n(inta_n), .eoi(eoi), .int_out(int_out),
    .data_out(data_out), .data_oe(data_oe), .cas_out(cas_out), .in_service(in_service)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one acknowledge pulse: values sampled one cycle after inta_n falls
  task automatic pulse(output logic [7:0] d, output logic oe,
                       output logic [2:0] cs, output logic iq);
    inta_n = 1'b0;
    tick(1);
    d = data_out; oe = data_oe; cs = cas_out; iq = int_out;
    tick(1);
    inta_n = 1'b1;
    tick(1);
    chk("R11 oe released after pulse", data_oe, 0);
  endtask

  task automatic strobe_eoi();
    eoi = 1'b1; tick(1); eoi = 1'b0; tick(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, iq;
    logic [2:0] cs;
    logic [7:0] exp_lo;

    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 reset int_out", int_out, 0);
    chk("R1 reset data_oe", data_oe, 0);
    chk("R1 reset cas_out", cas_out, 0);
    chk("R1 reset in_service", in_service, 0);

    // sweep: spacing x auto-eoi x level
    for (int st = 0; st < 2; st++) begin
      for (int ae = 0; ae < 2; ae++) begin
        for (int lv = 0; lv < 8; lv++) begin
          step_is_8 = st[0]; auto_eoi = ae[0];
          vec_base_lo = 8'h5B ^ 8'(lv * 37);
          vec_base_hi = 8'h30 + 8'(lv);
          req_in = 8'(1 << lv);
          tick(3);
          chk("R2 int after request", int_out, 1);
          pulse(d, oe, cs, iq);
          chk("R4 call byte", d, 8'hCD);
          chk("R4 call byte enabled", oe, 1);
          chk("R12 int low in pulse", iq, 0);
          chk("R7 isr set at first pulse", in_service, 32'(1 << lv));
          pulse(d, oe, cs, iq);
          exp_lo = st ? ((vec_base_lo & 8'hC0) | 8'(lv * 8))
                      : ((vec_base_lo & 8'hE0) | 8'(lv * 4));
          chk("R5 low address byte", d, exp_lo);
          chk("R11 low byte enabled", oe, 1);
          chk("R7 isr after second pulse", in_service, ae ? 0 : 32'(1 << lv));
          pulse(d, oe, cs, iq);
          chk("R6 high address byte", d, vec_base_hi);
          tick(2);
          chk("R1 held line no re-request", int_out, 0);
          if (ae == 0) begin
            chk("R7 isr held without eoi", in_service, 32'(1 << lv));
            strobe_eoi();
            chk("R8 eoi clears level", in_service, 0);
          end
          req_in = '0;
          tick(1);
        end
      end
    end

    // slave levels: cascade address and no drive for address bytes
    slave_map = 8'hFF; auto_eoi = 1'b1; step_is_8 = 1'b0;
    for (int lv = 0; lv < 8; lv++) begin
      req_in = 8'(1 << lv);
      tick(3);
      pulse(d, oe, cs, iq);
      chk("R4 slave call byte", d, 8'hCD);
      chk("R4 slave call enabled", oe, 1);
      chk("R10 cas at first pulse", cs, lv);
      pulse(d, oe, cs, iq);
      chk("R10 no drive second byte", oe, 0);
      chk("R10 cas at second pulse", cs, lv);
      pulse(d, oe, cs, iq);
      chk("R10 no drive third byte", oe, 0);
      chk("R10 cas at third pulse", cs, lv);
      tick(1);
      chk("R10 cas idle after sequence", cas_out, 0);
      req_in = '0;
      tick(1);
    end

    // spurious: request vanishes, level 7 is a slave
    slave_map = 8'h80; auto_eoi = 1'b0; vec_base_lo = 8'h40; vec_base_hi = 8'h99;
    req_in = 8'h08;
    tick(3);
    chk("R2 int for short request", int_out, 1);
    req_in = '0;
    tick(3);
    chk("R1 dropped line discards", int_out, 0);
    pulse(d, oe, cs, iq);
    chk("R9 spurious call byte", d, 8'hCD);
    chk("R9 spurious isr untouched", in_service, 0);
    chk("R10 spurious cas idle", cs, 0);
    pulse(d, oe, cs, iq);
    chk("R9 spurious level 7 byte", d, 8'h5C);
    chk("R10 spurious master drives", oe, 1);
    chk("R10 spurious cas idle b2", cs, 0);
    pulse(d, oe, cs, iq);
    chk("R6 spurious high byte", d, 8'h99);
    chk("R10 spurious master drives b3", oe, 1);
    chk("R9 isr after spurious", in_service, 0);

    // priority and nesting
    slave_map = '0; vec_base_lo = 8'h00;
    req_in = 8'h24;
    tick(3);
    chk("R2 int two requests", int_out, 1);
    pulse(d, oe, cs, iq); pulse(d, oe, cs, iq);
    chk("R3 lowest level wins", d, 8'h08);
    pulse(d, oe, cs, iq);
    chk("R3 isr level 2", in_service, 8'h04);
    tick(2);
    chk("R2 lower priority blocked", int_out, 0);
    req_in = 8'h26;
    tick(3);
    chk("R2 nested higher level", int_out, 1);
    pulse(d, oe, cs, iq); pulse(d, oe, cs, iq);
    chk("R3 nested level 1", d, 8'h04);
    pulse(d, oe, cs, iq);
    chk("R7 nested isr", in_service, 8'h06);
    strobe_eoi();
    chk("R8 eoi clears lowest only", in_service, 8'h04);
    tick(2);
    chk("R2 still blocked by level 2", int_out, 0);
    strobe_eoi();
    chk("R8 second eoi", in_service, 8'h00);
    tick(2);
    chk("R2 level 5 now eligible", int_out, 1);
    pulse(d, oe, cs, iq); pulse(d, oe, cs, iq);
    chk("R3 level 5 acknowledged", d, 8'h14);
    pulse(d, oe, cs, iq);
    strobe_eoi();
    req_in = '0;
    tick(2);

    // mask
    irq_mask = 8'h10; req_in = 8'h10;
    tick(3);
    chk("R2 masked request quiet", int_out, 0);
    irq_mask = 8'h00;
    tick(2);
    chk("R2 unmasked request", int_out, 1);
    pulse(d, oe, cs, iq); pulse(d, oe, cs, iq);
    chk("R5 unmasked level 4", d, 8'h10);
    pulse(d, oe, cs, iq);
    strobe_eoi();
    chk("R8 final isr clear", in_service, 0);

    done = 1'b1;
    finish_run();
  end
endmodule